// File: doc/BRIEF.md
# Accumulator Rotate and Flag Unit

This block computes the result of seven single-byte accumulator operations: four rotates (circular left, circular right, left through carry, right through carry), accumulator complement, carry set and carry complement. It takes the current 8-bit accumulator, the current 8-bit flag byte and a 3-bit operation code. It returns the new accumulator and the new flag byte. Each operation keeps or changes the flag bits by its own rule. An 8-bit execution stage uses it beside its main arithmetic unit.

Flag bits sit at fixed positions: sign 7, zero 6, an undocumented copy bit 5, half-carry 4, an undocumented copy bit 3, parity/overflow 2, subtract 1 and carry 0. The result logic is purely combinational. A parameter chooses whether a register follows it. The register is present by default. When it is present, the outputs follow the inputs with one cycle of latency and a synchronous active-high reset clears them.

Top module: `acc_rotflag_unit`

## Requirements
- R1: Operation code 0 (circular left) gives the accumulator {a[6:0], a[7]} and places old a[7] in carry.
- R2: Operation code 1 (circular right) gives {a[0], a[7:1]} and places old a[0] in carry.
- R3: Operation code 2 (left through carry) gives {a[6:0], old C} and places old a[7] in carry.
- R4: Operation code 3 (right through carry) gives {old C, a[7:1]} and places old a[0] in carry.
- R5: For operation codes 0 to 3, flag bits 7, 6, 5, 3 and 2 keep their values (mask 0xEC), H (bit 4) and N (bit 1) are cleared, and C (bit 0) holds the bit rotated out.
- R6: Operation code 4 inverts all eight accumulator bits, sets H and N, and leaves every other flag bit unchanged.
- R7: Operation code 5 leaves the accumulator unchanged, clears H and N, sets C, and keeps every other flag bit.
- R8: Operation code 6 leaves the accumulator unchanged, clears N, sets H to the old C, inverts C, and keeps every other flag bit.
- R9: Operation code 7 passes the accumulator and the flags through unchanged.
- R10: With the output register enabled, the outputs show the result for the inputs of the previous clock edge. A reset seen at an edge drives both outputs to 0x00, whatever the operation present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_sel | input | 3 | Operation code, 0 to 7 |
| acc_in | input | 8 | Current accumulator |
| flags_in | input | 8 | Current flag byte |
| acc_out | output | 8 | New accumulator |
| flags_out | output | 8 | New flag byte |

## Verification
Reset and an operation can arrive at the same clock edge. To provoke this, the bench asserts reset while a complement operation with a nonzero accumulator is already on the inputs. The bench judges that the outputs read 0x00 after that edge. One edge after reset is released, they must carry the complement result. The bench also sweeps every accumulator value against sixteen flag patterns for each code. It compares each result with its own model. Hand-worked vectors cover the carry-in and carry-out boundaries.

// File: rtl/accrot_pkg.sv
package accrot_pkg;

    localparam int DW = 8;

    localparam int FB_C  = 0;
    localparam int FB_N  = 1;
    localparam int FB_PV = 2;
    localparam int FB_H  = 4;
    localparam int FB_Z  = 6;
    localparam int FB_S  = 7;

    localparam logic [DW-1:0] ROT_KEEP_MASK = 8'hEC;

    typedef enum logic [2:0] {
        OP_ROL_CIRC   = 3'd0,
        OP_ROR_CIRC   = 3'd1,
        OP_ROL_CARRY  = 3'd2,
        OP_ROR_CARRY  = 3'd3,
        OP_INVERT     = 3'd4,
        OP_CARRY_SET  = 3'd5,
        OP_CARRY_FLIP = 3'd6,
        OP_HOLD       = 3'd7
    } acc_op_e;

    typedef struct packed {
        logic [DW-1:0] acc;
        logic [DW-1:0] flg;
    } acc_state_t;

    function automatic logic is_rotate(input acc_op_e op);
        return (op[2] == 1'b0);
    endfunction

endpackage

// File: rtl/acc_rotator.sv
module acc_rotator
    import accrot_pkg::*;
(
    input  acc_state_t  cur,
    input  logic        go_right,
    input  logic        via_carry,
    output acc_state_t  nxt
);
    logic out_bit;
    logic in_bit;

    always_comb begin
        out_bit = go_right ? cur.acc[0] : cur.acc[DW-1];
        in_bit  = via_carry ? cur.flg[FB_C] : out_bit;
        if (go_right)
            nxt.acc = {in_bit, cur.acc[DW-1:1]};
        else
            nxt.acc = {cur.acc[DW-2:0], in_bit};
        nxt.flg = (cur.flg & ROT_KEEP_MASK) | {{(DW-1){1'b0}}, out_bit};
    end

    always_comb begin
        if (!$isunknown(cur)) begin
            AST_ROT_CARRY_OUT: assert (nxt.flg[FB_C] == (go_right ? cur.acc[0] : cur.acc[DW-1])); // R5
        end
    end
endmodule

// File: rtl/acc_flag_ops.sv
module acc_flag_ops
    import accrot_pkg::*;
(
    input  acc_state_t  cur,
    input  acc_op_e     op,
    output acc_state_t  nxt
);
    always_comb begin
        nxt = cur;
        unique case (op)
            OP_INVERT: begin
                nxt.acc       = ~cur.acc;
                nxt.flg[FB_H] = 1'b1;
                nxt.flg[FB_N] = 1'b1;
            end
            OP_CARRY_SET: begin
                nxt.flg[FB_H] = 1'b0;
                nxt.flg[FB_N] = 1'b0;
                nxt.flg[FB_C] = 1'b1;
            end
            OP_CARRY_FLIP: begin
                nxt.flg[FB_N] = 1'b0;
                nxt.flg[FB_H] = cur.flg[FB_C];
                nxt.flg[FB_C] = ~cur.flg[FB_C];
            end
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/acc_rotflag_unit.sv
module acc_rotflag_unit
    import accrot_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    op_sel,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] flags_in,
    output logic [DW-1:0] acc_out,
    output logic [DW-1:0] flags_out
);
    acc_op_e    op;
    acc_state_t cur;
    acc_state_t rot_res;
    acc_state_t fop_res;
    acc_state_t result;

    assign op      = acc_op_e'(op_sel);
    assign cur.acc = acc_in;
    assign cur.flg = flags_in;

    acc_rotator u_rot (
        .cur       (cur),
        .go_right  (op_sel[0]),
        .via_carry (op_sel[1]),
        .nxt       (rot_res)
    );

    acc_flag_ops u_fop (
        .cur (cur),
        .op  (op),
        .nxt (fop_res)
    );

    assign result = is_rotate(op) ? rot_res : fop_res;

    generate
        if (REG_OUT) begin : g_reg
            acc_state_t q;
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= result;
            end
            assign acc_out   = q.acc;
            assign flags_out = q.flg;

            AST_RST_CLEAR: assert property (@(posedge clk) rst |=> (acc_out == '0 && flags_out == '0)); // R10
            AST_ROT_FLAGS: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(op_sel) < 3'd4) |->
                ((flags_out & ROT_KEEP_MASK) == ($past(flags_in) & ROT_KEEP_MASK))); // R5
            AST_INV_FLAGS: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(op_sel) == 3'd4) |->
                (flags_out == ($past(flags_in) | 8'h12) && acc_out == ~$past(acc_in))); // R6
            AST_SET_CARRY: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(op_sel) == 3'd5) |->
                (flags_out == (($past(flags_in) & 8'hEC) | 8'h01) && acc_out == $past(acc_in))); // R7
            AST_FLIP_CARRY: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(op_sel) == 3'd6) |->
                (flags_out[FB_H] == $past(flags_in[FB_C]) && flags_out[FB_C] != $past(flags_in[FB_C]) && !flags_out[FB_N])); // R8
            AST_HOLD_PASS: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(op_sel) == 3'd7) |->
                (flags_out == $past(flags_in) && acc_out == $past(acc_in))); // R9
        end else begin : g_comb
            assign acc_out   = result.acc;
            assign flags_out = result.flg;
        end
    endgenerate
endmodule

// File: tb/acc_rotflag_unit_tb.sv
module acc_rotflag_unit_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op_sel = 3'd0;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] flags_in = 8'h00;
    logic [7:0] acc_out;
    logic [7:0] flags_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    acc_rotflag_unit u_dut (
        .clk(clk), .rst(rst), .op_sel(op_sel),
        .acc_in(acc_in), .flags_in(flags_in),
        .acc_out(acc_out), .flags_out(flags_out)
    );

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] a;
        logic [7:0] f;
        logic [7:0] ea;
        logic [7:0] ef;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 8'h81, 8'h00, 8'h03, 8'h01},   // R1
        '{3'd1, 8'h01, 8'hFF, 8'h80, 8'hED},   // R2 R5
        '{3'd2, 8'h80, 8'h01, 8'h01, 8'h01},   // R3
        '{3'd2, 8'h00, 8'h01, 8'h01, 8'h00},   // R3
        '{3'd3, 8'h01, 8'h00, 8'h00, 8'h01},   // R4
        '{3'd3, 8'h00, 8'h13, 8'h80, 8'h00},   // R4 R5
        '{3'd4, 8'h5A, 8'h00, 8'hA5, 8'h12},   // R6
        '{3'd5, 8'h33, 8'h13, 8'h33, 8'h01},   // R7
        '{3'd6, 8'h44, 8'h01, 8'h44, 8'h10},   // R8
        '{3'd6, 8'h44, 8'h12, 8'h44, 8'h01},   // R8
        '{3'd7, 8'h9C, 8'hD7, 8'h9C, 8'hD7}    // R9
    };

    function automatic logic [15:0] model(input logic [2:0] op, input logic [7:0] a, input logic [7:0] f);
        logic [7:0] ra;
        logic [7:0] rf;
        ra = a; rf = f;
        case (op)
            3'd0: begin ra = {a[6:0], a[7]}; rf = (f & 8'hEC) | {7'd0, a[7]}; end
            3'd1: begin ra = {a[0], a[7:1]}; rf = (f & 8'hEC) | {7'd0, a[0]}; end
            3'd2: begin ra = {a[6:0], f[0]}; rf = (f & 8'hEC) | {7'd0, a[7]}; end
            3'd3: begin ra = {f[0], a[7:1]}; rf = (f & 8'hEC) | {7'd0, a[0]}; end
            3'd4: begin ra = ~a; rf = f | 8'h12; end
            3'd5: begin rf = (f & 8'hEC) | 8'h01; end
            3'd6: begin rf = (f & 8'hEC) | (f[0] ? 8'h10 : 8'h01); end
            default: ;
        endcase
        return {ra, rf};
    endfunction

    task automatic check(input string req, input logic [7:0] ea, input logic [7:0] ef);
        n_checks++;
        if (acc_out !== ea || flags_out !== ef) begin
            n_fail++;
            $display("FAIL %s: acc=%02h flags=%02h expected acc=%02h flags=%02h", req, acc_out, flags_out, ea, ef);
        end
    endtask

    task automatic run_one(input string req, input logic [2:0] op, input logic [7:0] a,
                           input logic [7:0] f, input logic [7:0] ea, input logic [7:0] ef);
        @(negedge clk);
        op_sel = op; acc_in = a; flags_in = f;
        @(negedge clk);
        check(req, ea, ef);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000 && !done) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: acc=%02h flags=%02h expected completion", acc_out, flags_out);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp_v;
        repeat (2) @(negedge clk);
        check("R10 reset state", 8'h00, 8'h00);

        // R10: reset and a complement in the same cycle; reset dominates
        op_sel = 3'd4; acc_in = 8'h5A; flags_in = 8'h00;
        @(negedge clk);
        check("R10 reset wins", 8'h00, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R10 latency after release", 8'hA5, 8'h12);

        for (int i = 0; i < NV; i++) begin
            run_one($sformatf("R1..9 table vec %0d op %0d", i, VEC[i].op),
                    VEC[i].op, VEC[i].a, VEC[i].f, VEC[i].ea, VEC[i].ef);
        end

        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int k = 0; k < 16; k++) begin
                    logic [7:0] f;
                    f = 8'(k * 17) ^ {4'd0, k[0], k[1], k[2], k[3]};
                    exp_v = model(3'(op), 8'(a), f);
                    run_one($sformatf("sweep op %0d (R1 R2 R3 R4 R5 R6 R7 R8 R9)", op),
                            3'(op), 8'(a), f, exp_v[15:8], exp_v[7:0]);
                end
            end
        end

        // R10 reset mid-run clears outputs
        @(negedge clk);
        op_sel = 3'd7; acc_in = 8'hFF; flags_in = 8'hFF; rst = 1'b1;
        @(negedge clk);
        check("R10 reset mid-run", 8'h00, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R9 pass after reset", 8'hFF, 8'hFF);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule